// File: doc/BRIEF.md
# Multichannel ADC Byte-Readout Sequencer

This block drains one conversion result from an eight-channel, 16-bit simultaneous-sampling converter whose data bus is one byte wide. When the converter's busy line falls, the sequencer strobes an active-low output enable once per byte and captures the byte while the strobe is low. It then joins each pair of bytes into a channel word and writes the word into a linear sample buffer at a write index that wraps at the buffer depth.

A host arms the block once per acquisition. From then on the block counts every byte it reads against a transfer length. That length is normally set to two bytes times eight channels times the sample rate, which is one second of data. When the count reaches the length, the block stops and holds a done flag. At a fixed, configurable frame interval it also pulses a frame-ready flag that carries the next buffer write position, so the host learns where fresh data ends without an event per sample. A busy fall that arrives while a burst is still running is ignored and recorded in a sticky overrun flag.

Top module: `adc_byte_seq`

## Requirements
- R1: After reset, oe_n is 1 and wr_en, frame_rdy, done, overrun and active are all 0.
- R2: While active, a busy_in fall is passed through a two-flop synchroniser. oe_n first goes low on the third rising clock edge after busy_in is seen low. Each byte then takes one cycle with oe_n low and one cycle with oe_n high, and adc_data is sampled at the edge that ends the low cycle. One burst gives exactly 16 low pulses.
- R3: Each word is the first byte of a pair in bits 15:8 and the second byte in bits 7:0. Channels 0 to 7 come out in that order. wr_en is high for exactly one cycle, starting at the edge that captures the second byte of the pair.
- R4: After arm, wr_addr is 0 for the first word. It advances by one after every word and wraps to 0 after BUF_DEPTH-1.
- R5: While active, frame_rdy is a one-cycle pulse that appears frame_len cycles after the arm edge and then every frame_len cycles (frame_len must be at least 2). Alongside each pulse, frame_idx gives the number of words written since arm, modulo BUF_DEPTH.
- R6: When the number of bytes read since arm reaches xfer_len, done goes to 1 and active goes to 0. After that, busy_in falls cause no strobes and no writes. xfer_len is taken as a multiple of 16.
- R7: A busy_in fall that is detected while a burst is running sets overrun, which stays set. The running burst still completes its 16 strobes and 8 words unchanged.
- R8: While the block is not active, busy_in falls produce no strobes and do not set overrun.
- R9: An arm pulse clears done, overrun, the write index, the byte count and the frame timer, and sets active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle pulse that starts an acquisition |
| frame_len | input | FR_W (24) | Frame interval in clock cycles |
| xfer_len | input | CNT_W (24) | Bytes per acquisition |
| busy_in | input | 1 | Converter busy line, asynchronous |
| adc_data | input | BUS_W (8) | Converter byte bus |
| oe_n | output | 1 | Active-low output enable strobe |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | log2(BUF_DEPTH) (4) | Buffer write index |
| wr_data | output | SAMPLE_W (16) | Assembled channel word |
| frame_rdy | output | 1 | Frame-ready pulse |
| frame_idx | output | log2(BUF_DEPTH) (4) | Next write position reported with frame_rdy |
| done | output | 1 | Transfer length reached |
| active | output | 1 | Acquisition running |
| overrun | output | 1 | Sticky flag for a busy fall during a burst |

## Verification
Counting from the falling edge of the clock on which busy_in is driven low, the bench expects oe_n high at the first two falling edges and low at the third. It expects wr_en for channel 0 at the sixth falling edge, and the next word four cycles after each word. frame_rdy is expected exactly frame_len falling edges after the one that ends the arm pulse. Every output is sampled on falling edges only, so each check looks at the state left by one known rising edge. A monitor compares every buffer write and every frame report with a byte stream and word count that the bench keeps itself. Per-burst strobe and word counts cover the completion, overrun and ignore cases.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_LOW  = 2'd1,
    RD_HIGH = 2'd2
  } rd_state_t;
endpackage

// File: rtl/adc_busy_edge.sv
module adc_busy_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_in,
  output logic busy_fall
);
  logic [SYNC_STAGES:0] sync_q;
  logic [SYNC_STAGES:0] sync_d;

  always_comb sync_d = {sync_q[SYNC_STAGES-1:0], busy_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  // previous synchronised level high, current low
  assign busy_fall = sync_q[SYNC_STAGES] & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/adc_burst_rd.sv
module adc_burst_rd
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 16,
  parameter int BUS_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                halt,
  input  logic [BUS_W-1:0]    adc_data,
  output logic                oe_n,
  output logic                byte_stb,
  output logic                in_burst,
  output logic                word_vld,
  output logic [SAMPLE_W-1:0] word_data
);
  localparam int BYTES_PER_CH = SAMPLE_W / BUS_W;
  localparam int BURST_BYTES  = NUM_CH * BYTES_PER_CH;
  localparam int BC_W         = $clog2(BURST_BYTES + 1);
  localparam int PART_W       = $clog2(BYTES_PER_CH);
  localparam logic [PART_W-1:0] PART_LAST = PART_W'(BYTES_PER_CH - 1);

  rd_state_t            st_q, st_d;
  logic                 oe_q, oe_d;
  logic [BC_W-1:0]      bcnt_q, bcnt_d;
  logic [PART_W-1:0]    part_q, part_d;
  logic [SAMPLE_W-1:0]  acc_q, acc_d;
  logic                 wv_q, wv_d;
  logic [SAMPLE_W-1:0]  wd_q, wd_d;

  always_comb begin
    st_d   = st_q;
    oe_d   = oe_q;
    bcnt_d = bcnt_q;
    part_d = part_q;
    acc_d  = acc_q;
    wv_d   = 1'b0;
    wd_d   = wd_q;
    unique case (st_q)
      RD_IDLE: begin
        if (start) begin
          st_d   = RD_LOW;
          oe_d   = 1'b0;
          bcnt_d = '0;
          part_d = '0;
        end
      end
      RD_LOW: begin
        acc_d  = {acc_q[SAMPLE_W-BUS_W-1:0], adc_data};
        bcnt_d = bcnt_q + 1'b1;
        oe_d   = 1'b1;
        st_d   = RD_HIGH;
        if (part_q == PART_LAST) begin
          wv_d   = 1'b1;
          wd_d   = {acc_q[SAMPLE_W-BUS_W-1:0], adc_data};
          part_d = '0;
        end else begin
          part_d = part_q + 1'b1;
        end
      end
      RD_HIGH: begin
        if (halt || bcnt_q == BC_W'(BURST_BYTES)) begin
          st_d = RD_IDLE;
        end else begin
          st_d = RD_LOW;
          oe_d = 1'b0;
        end
      end
      default: st_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      oe_q   <= 1'b1;
      bcnt_q <= '0;
      part_q <= '0;
      acc_q  <= '0;
      wv_q   <= 1'b0;
      wd_q   <= '0;
    end else begin
      st_q   <= st_d;
      oe_q   <= oe_d;
      bcnt_q <= bcnt_d;
      part_q <= part_d;
      acc_q  <= acc_d;
      wv_q   <= wv_d;
      wd_q   <= wd_d;
    end
  end

  assign oe_n      = oe_q;
  assign byte_stb  = (st_q == RD_LOW);
  assign in_burst  = (st_q != RD_IDLE);
  assign word_vld  = wv_q;
  assign word_data = wd_q;

  // R2
  oe_single_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |=> oe_n);

  // R3
  wr_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(!oe_n));
endmodule

// File: rtl/adc_buf_track.sv
module adc_buf_track #(
  parameter int IDX_W = 4,
  parameter int CNT_W = 24,
  parameter int FR_W  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             byte_stb,
  input  logic             word_vld,
  input  logic             overrun_evt,
  input  logic [FR_W-1:0]  frame_len,
  input  logic [CNT_W-1:0] xfer_len,
  output logic [IDX_W-1:0] wr_addr,
  output logic             frame_rdy,
  output logic [IDX_W-1:0] frame_idx,
  output logic             done,
  output logic             active,
  output logic             overrun
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] byt_q, byt_d;
  logic [FR_W-1:0]  fcnt_q, fcnt_d;
  logic             frdy_q, frdy_d;
  logic [IDX_W-1:0] fidx_q, fidx_d;
  logic             done_q, done_d;
  logic             act_q, act_d;
  logic             ovr_q, ovr_d;

  always_comb begin
    idx_d  = idx_q;
    byt_d  = byt_q;
    fcnt_d = fcnt_q;
    frdy_d = 1'b0;
    fidx_d = fidx_q;
    done_d = done_q;
    act_d  = act_q;
    ovr_d  = ovr_q;
    if (arm) begin
      idx_d  = '0;
      byt_d  = '0;
      fcnt_d = '0;
      fidx_d = '0;
      done_d = 1'b0;
      act_d  = 1'b1;
      ovr_d  = 1'b0;
    end else begin
      if (word_vld) idx_d = idx_q + 1'b1;
      if (overrun_evt) ovr_d = 1'b1;
      if (act_q && byte_stb) begin
        byt_d = byt_q + 1'b1;
        if ((byt_q + 1'b1) == xfer_len) begin
          done_d = 1'b1;
          act_d  = 1'b0;
        end
      end
      if (act_q) begin
        if (fcnt_q == frame_len - 1'b1) begin
          fcnt_d = '0;
          frdy_d = 1'b1;
          fidx_d = idx_q + IDX_W'(word_vld);
        end else begin
          fcnt_d = fcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      byt_q  <= '0;
      fcnt_q <= '0;
      frdy_q <= 1'b0;
      fidx_q <= '0;
      done_q <= 1'b0;
      act_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      byt_q  <= byt_d;
      fcnt_q <= fcnt_d;
      frdy_q <= frdy_d;
      fidx_q <= fidx_d;
      done_q <= done_d;
      act_q  <= act_d;
      ovr_q  <= ovr_d;
    end
  end

  assign wr_addr   = idx_q;
  assign frame_rdy = frdy_q;
  assign frame_idx = fidx_q;
  assign done      = done_q;
  assign active    = act_q;
  assign overrun   = ovr_q;

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld && !arm |=> wr_addr == $past(wr_addr) + 1'b1);

  // R5
  frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rdy && frame_len > 1 |=> !frame_rdy);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !arm |=> overrun);

  // R9
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> active && !done && !overrun && wr_addr == '0);
endmodule

// File: rtl/adc_byte_seq.sv
module adc_byte_seq #(
  parameter int NUM_CH      = 8,
  parameter int SAMPLE_W    = 16,
  parameter int BUS_W       = 8,
  parameter int BUF_DEPTH   = 16,
  parameter int FR_W        = 24,
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(BUF_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm,
  input  logic [FR_W-1:0]     frame_len,
  input  logic [CNT_W-1:0]    xfer_len,
  input  logic                busy_in,
  input  logic [BUS_W-1:0]    adc_data,
  output logic                oe_n,
  output logic                wr_en,
  output logic [IDX_W-1:0]    wr_addr,
  output logic [SAMPLE_W-1:0] wr_data,
  output logic                frame_rdy,
  output logic [IDX_W-1:0]    frame_idx,
  output logic                done,
  output logic                active,
  output logic                overrun
);
  logic busy_fall;
  logic byte_stb;
  logic in_burst;
  logic start;
  logic overrun_evt;

  adc_busy_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_in  (busy_in),
    .busy_fall(busy_fall)
  );

  assign start       = busy_fall & active & ~in_burst;
  assign overrun_evt = busy_fall & active & in_burst;

  adc_burst_rd #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .BUS_W(BUS_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .halt     (done),
    .adc_data (adc_data),
    .oe_n     (oe_n),
    .byte_stb (byte_stb),
    .in_burst (in_burst),
    .word_vld (wr_en),
    .word_data(wr_data)
  );

  adc_buf_track #(.IDX_W(IDX_W), .CNT_W(CNT_W), .FR_W(FR_W)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .byte_stb   (byte_stb),
    .word_vld   (wr_en),
    .overrun_evt(overrun_evt),
    .frame_len  (frame_len),
    .xfer_len   (xfer_len),
    .wr_addr    (wr_addr),
    .frame_rdy  (frame_rdy),
    .frame_idx  (frame_idx),
    .done       (done),
    .active     (active),
    .overrun    (overrun)
  );

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !in_burst |=> oe_n);
endmodule

// File: tb/adc_byte_seq_test.sv
module adc_byte_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic [23:0] frame_len = 24'd30;
  logic [23:0] xfer_len = 24'd100000;
  logic        busy_in = 1'b1;
  logic [7:0]  adc_data = 8'h00;
  logic        oe_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic        frame_rdy;
  logic [3:0]  frame_idx;
  logic        done;
  logic        active;
  logic        overrun;

  int checks = 0;
  int fails = 0;
  int bcnt = 0;
  int strobes = 0;
  int wglob = 0;
  int warm = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_byte_seq uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .frame_len(frame_len),
    .xfer_len(xfer_len), .busy_in(busy_in), .adc_data(adc_data),
    .oe_n(oe_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_rdy(frame_rdy), .frame_idx(frame_idx), .done(done),
    .active(active), .overrun(overrun)
  );

  function automatic logic [7:0] pat(int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: a new byte is presented on each strobe
  always @(negedge oe_n) begin
    adc_data = pat(bcnt);
    bcnt++;
    strobes++;
  end

  // monitor of buffer writes and frame reports
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_rdy) chk(int'(frame_idx) == warm % 16, "R5 frame_idx", int'(frame_idx), warm % 16);
      if (wr_en) begin
        chk(wr_data == {pat(2 * wglob), pat(2 * wglob + 1)}, "R3 word",
            int'(wr_data), int'({pat(2 * wglob), pat(2 * wglob + 1)}));
        chk(int'(wr_addr) == warm % 16, "R4 wr_addr", int'(wr_addr), warm % 16);
        wglob++;
        warm++;
      end
    end
  end

  task automatic do_arm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
    warm = 0;
  endtask

  task automatic burst(int hold);
    @(negedge clk) busy_in = 1'b0;
    repeat (hold) @(negedge clk);
    busy_in = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(oe_n == 1'b1, "R1 oe_n", int'(oe_n), 1);
    chk(!wr_en && !frame_rdy, "R1 wr_en/frame_rdy", int'(wr_en | frame_rdy), 0);
    chk(!done && !overrun && !active, "R1 flags", int'({done, overrun, active}), 0);
  endtask

  task automatic t_idle();
    int s0 = strobes;
    int w0 = wglob;
    burst(40);
    chk(strobes == s0, "R8 no strobes", strobes - s0, 0);
    chk(wglob == w0, "R8 no writes", wglob - w0, 0);
    chk(!overrun, "R8 overrun", int'(overrun), 0);
  endtask

  task automatic t_timing();
    int s0;
    int w0;
    frame_len = 24'd30;
    xfer_len = 24'd100000;
    do_arm();
    chk(active && !done && !overrun && wr_addr == 4'd0, "R9 arm state", int'({active, done, overrun}), 4);
    s0 = strobes;
    w0 = wglob;
    @(negedge clk) busy_in = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 1 || k == 2) chk(oe_n == 1'b1, "R2 sync delay", int'(oe_n), 1);
      if (k == 3) chk(oe_n == 1'b0, "R2 first strobe", int'(oe_n), 0);
      if (k == 4) chk(oe_n == 1'b1, "R2 strobe high", int'(oe_n), 1);
      if (k == 5) chk(wr_en == 1'b0, "R3 wr_en early", int'(wr_en), 0);
      if (k == 6) chk(wr_en == 1'b1, "R3 wr_en ch0", int'(wr_en), 1);
      if (k == 7) chk(wr_en == 1'b0, "R3 wr_en single", int'(wr_en), 0);
    end
    busy_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(strobes - s0 == 16, "R2 strobe count", strobes - s0, 16);
    chk(wglob - w0 == 8, "R3 word count", wglob - w0, 8);
  endtask

  task automatic t_patterns();
    int w0 = wglob;
    for (int b = 0; b < 3; b++) burst(40);
    chk(wglob - w0 == 24, "R4 words across wrap", wglob - w0, 24);
    chk(int'(wr_addr) == warm % 16, "R4 wrapped index", int'(wr_addr), warm % 16);
  endtask

  task automatic t_frame();
    int first = -1;
    int second = -1;
    frame_len = 24'd50;
    do_arm();
    for (int n = 1; n <= 110; n++) begin
      @(negedge clk);
      if (frame_rdy && first < 0) first = n;
      else if (frame_rdy && second < 0) second = n;
    end
    chk(first == 50, "R5 first frame", first, 50);
    chk(second == 100, "R5 second frame", second, 100);
  endtask

  task automatic t_overrun();
    int s0;
    int w0;
    frame_len = 24'd30;
    xfer_len = 24'd100000;
    do_arm();
    s0 = strobes;
    w0 = wglob;
    @(negedge clk) busy_in = 1'b0;
    repeat (10) @(negedge clk);
    busy_in = 1'b1;
    repeat (3) @(negedge clk);
    busy_in = 1'b0;
    repeat (30) @(negedge clk);
    busy_in = 1'b1;
    repeat (5) @(negedge clk);
    chk(overrun == 1'b1, "R7 overrun set", int'(overrun), 1);
    chk(strobes - s0 == 16, "R7 burst strobes", strobes - s0, 16);
    chk(wglob - w0 == 8, "R7 burst words", wglob - w0, 8);
    burst(40);
    chk(overrun == 1'b1, "R7 overrun sticky", int'(overrun), 1);
    do_arm();
    chk(overrun == 1'b0, "R9 overrun cleared", int'(overrun), 0);
  endtask

  task automatic t_done();
    int s0;
    int w0;
    xfer_len = 24'd32;
    do_arm();
    burst(40);
    chk(!done && active, "R6 not yet done", int'(done), 0);
    burst(40);
    chk(done && !active, "R6 done", int'({done, active}), 2);
    s0 = strobes;
    w0 = wglob;
    burst(40);
    chk(strobes == s0, "R6 no strobes after done", strobes - s0, 0);
    chk(wglob == w0, "R6 no writes after done", wglob - w0, 0);
    chk(!overrun, "R8 no overrun after done", int'(overrun), 0);
    do_arm();
    chk(!done && active, "R9 re-armed", int'({done, active}), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_timing();
    t_patterns();
    t_frame();
    t_overrun();
    t_done();
    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule